// File: doc/BRIEF.md
# Rounding Dual Adder for Pre-Normalized Significands

This block finishes a floating-point significand in one pass. It takes the upper part of a result that is already normalized, held as two redundant words (a sum word and a carry word). It also takes the bits that summarize everything below that part: how many carries the lower bits pass upward (zero, one or two), a flag that supplies the missing +1 of a two's-complement negation, and the guard, round and sticky bits. It returns the significand rounded to nearest with ties to even.

The operands arrive normalized, so the rounding position is always the least-significant bit of the upper field. Rounding therefore needs no separate increment stage. The carries from below and the completion bit are first folded into the redundant pair by a single 3:2 compression row. A prefix dual adder then produces the total and the total plus one together. The rounding decision picks one of the two. The least-significant bit of the unrounded total comes straight from the compression row, so the decision does not wait for the carry chain. If the selected total overflows the field, a carry-out flag tells the downstream exponent logic to increment the exponent and shift right by one. The result is registered once, with a valid flag.

Top module: `darAddRound`

## Requirements
- R1: When `inValid` is 1, the value {`outCarry`,`outSig`} one cycle later equals (`inSum` + `inCarry` + `inLowCarry` + `inComplete` + up) modulo 2^(SIG_W+1), where up is the rounding increment of R4.
- R2: `inLowCarry` is an unsigned count of 0, 1 or 2 carries entering the upper field at its least-significant bit; the code 3 is never presented with `inValid` high.
- R3: `inComplete` = 1 adds exactly one unit at the least-significant bit of the upper field, on top of the low carries.
- R4: The rounding increment is 1 exactly when `inGuard` is 1 and at least one of `inRound`, `inSticky` or the least-significant bit of the unrounded total (`inSum`+`inCarry`+`inLowCarry`+`inComplete`) is 1.
- R5: With `inGuard` = 0 the result is the unrounded total, whatever `inRound` and `inSticky` are.
- R6: A tie (`inGuard`=1, `inRound`=0, `inSticky`=0) always gives a result whose bit 0 is 0.
- R7: `outCarry` is bit SIG_W of the rounded total and `outSig` holds bits SIG_W-1..0.
- R8: `outValid` is 1 in the cycle after a cycle with `inValid` = 1, and 0 in the cycle after a cycle with `inValid` = 0.
- R9: While `inValid` is 0, `outSig` and `outCarry` keep their last values, whatever the other inputs do.
- R10: After reset, `outValid`, `outSig` and `outCarry` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input operands are present this cycle |
| inSum | input | SIG_W | Sum word of the normalized upper field |
| inCarry | input | SIG_W | Carry word of the normalized upper field |
| inLowCarry | input | 2 | Count of carries from the lower bits (0 to 2) |
| inComplete | input | 1 | Adds the +1 that completes a two's complement |
| inGuard | input | 1 | First bit below the upper field |
| inRound | input | 1 | Second bit below the upper field |
| inSticky | input | 1 | OR of all remaining lower bits |
| outValid | output | 1 | Registered result is valid |
| outSig | output | SIG_W | Rounded significand |
| outCarry | output | 1 | Rounded total overflowed the field |

## Verification
Every result, and its valid flag, is due exactly one rising edge after the cycle in which `inValid` was high. The bench drives each vector just after a falling edge and reads the outputs one time unit after the next rising edge, so each sample sees that vector's result and nothing else. The sweep presents one vector per cycle, which also checks that back-to-back operands do not disturb one another. The hold and idle checks read the outputs at the same point, one cycle after `inValid` drops.

// File: rtl/dar_pkg.sv
package dar_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic load;     // capture a new rounded result this cycle
    logic roundUp;  // select the incremented total
  } darStrobe_t;

  localparam int unsigned LOW_CARRY_W = 2;

endpackage

// File: rtl/darInjectRow.sv
// One 3:2 compression row that folds the low-order carries and the
// two's-complement completion bit into the redundant upper pair.
module darInjectRow #(
  parameter int unsigned SIG_W = 53
) (
  input  logic [SIG_W-1:0] sumIn,
  input  logic [SIG_W-1:0] carryIn,
  input  logic [1:0]       incr,
  output logic [SIG_W:0]   sumOut,
  output logic [SIG_W:0]   carryOut
);

  logic [SIG_W-1:0] third;

  genvar i;
  generate
    for (i = 0; i < SIG_W; i++) begin : g_bit
      if (i < 2) begin : g_inj
        assign third[i] = incr[i];
      end else begin : g_zero
        assign third[i] = 1'b0;
      end
      assign sumOut[i]     = sumIn[i] ^ carryIn[i] ^ third[i];
      assign carryOut[i+1] = (sumIn[i] & carryIn[i]) | (sumIn[i] & third[i]) |
                             (carryIn[i] & third[i]);
    end
  endgenerate

  assign sumOut[SIG_W] = 1'b0;
  assign carryOut[0]   = 1'b0;

endmodule

// File: rtl/darDualAdder.sv
// Parallel-prefix adder returning a+b and a+b+1 from one carry network.
module darDualAdder #(
  parameter int unsigned N = 54
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [N-1:0] total,
  output logic [N-1:0] totalInc
);

  localparam int unsigned LVLS = (N > 1) ? $clog2(N) : 1;

  logic [LVLS:0][N-1:0] grpG;
  logic [LVLS:0][N-1:0] grpP;
  logic [N-1:0]         bitP;
  logic [N-1:0]         cyPlain;
  logic [N-1:0]         cyInc;

  assign bitP    = opA ^ opB;
  assign grpG[0] = opA & opB;
  assign grpP[0] = bitP;

  genvar lv, i;
  generate
    for (lv = 0; lv < LVLS; lv++) begin : g_lvl
      for (i = 0; i < N; i++) begin : g_node
        if (i >= (1 << lv)) begin : g_merge
          assign grpG[lv+1][i] = grpG[lv][i] | (grpP[lv][i] & grpG[lv][i-(1<<lv)]);
          assign grpP[lv+1][i] = grpP[lv][i] & grpP[lv][i-(1<<lv)];
        end else begin : g_pass
          assign grpG[lv+1][i] = grpG[lv][i];
          assign grpP[lv+1][i] = grpP[lv][i];
        end
      end
    end

    for (i = 0; i < N; i++) begin : g_carry
      if (i == 0) begin : g_lsb
        assign cyPlain[i] = 1'b0;
        assign cyInc[i]   = 1'b1;
      end else begin : g_upper
        assign cyPlain[i] = grpG[LVLS][i-1];
        assign cyInc[i]   = grpG[LVLS][i-1] | grpP[LVLS][i-1];
      end
    end
  endgenerate

  assign total    = bitP ^ cyPlain;
  assign totalInc = bitP ^ cyInc;

endmodule

// File: rtl/darCtl.sv
// Control half: rounding decision and the valid pipeline.
module darCtl
  import dar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inGuard,
  input  logic       inRound,
  input  logic       inSticky,
  input  logic       lsbPre,
  output darStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe.load    = inValid;
    strobe.roundUp = inGuard & (inRound | inSticky | lsbPre);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R8: valid follows the input valid by exactly one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r8_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/darPath.sv
// Datapath half: carry injection, dual adder, selection and result register.
module darPath
  import dar_pkg::*;
#(
  parameter int unsigned SIG_W = 53
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  darStrobe_t             strobe,
  input  logic [SIG_W-1:0]       sumIn,
  input  logic [SIG_W-1:0]       carryIn,
  input  logic [LOW_CARRY_W-1:0] lowCarry,
  input  logic                   complete,
  output logic                   lsbPre,
  output logic [SIG_W-1:0]       rndSig,
  output logic                   rndCarry
);

  localparam int unsigned ADD_W = SIG_W + 1;

  logic [1:0]       incr;
  logic [ADD_W-1:0] rowSum;
  logic [ADD_W-1:0] rowCarry;
  logic [ADD_W-1:0] total;
  logic [ADD_W-1:0] totalInc;
  logic [ADD_W-1:0] picked;

  assign incr = lowCarry + {1'b0, complete};

  darInjectRow #(.SIG_W(SIG_W)) uRow (
    .sumIn   (sumIn),
    .carryIn (carryIn),
    .incr    (incr),
    .sumOut  (rowSum),
    .carryOut(rowCarry)
  );

  darDualAdder #(.N(ADD_W)) uAdd (
    .opA     (rowSum),
    .opB     (rowCarry),
    .total   (total),
    .totalInc(totalInc)
  );

  // The carry row has a zero LSB, so the total's LSB is known early.
  assign lsbPre = rowSum[0];
  assign picked = strobe.roundUp ? totalInc : total;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rndSig   <= '0;
      rndCarry <= 1'b0;
    end else if (strobe.load) begin
      rndSig   <= picked[SIG_W-1:0];
      rndCarry <= picked[SIG_W];
    end
  end

  // R1: the dual adder's two outputs are one unit apart
  a_r1_pair_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (totalInc == ADD_W'(total + 1'b1)));
  // R3: compression row plus adder reproduce the plain sum with injections
  a_r3_inject_total: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (total == ADD_W'({1'b0, sumIn} + {1'b0, carryIn} +
                                      ADD_W'(lowCarry) + ADD_W'(complete))));
  // R4: the early LSB matches the LSB of the carry-propagated total
  a_r4_early_lsb: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (lsbPre == total[0]));
  // R2: never more than two carries from below
  a_r2_low_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (lowCarry != 2'd3));
  // R9: result held while no new operand arrives
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(rndSig) && $stable(rndCarry)));

endmodule

// File: rtl/darAddRound.sv
// Thin top: combined add-and-round of a normalized redundant significand.
module darAddRound
  import dar_pkg::*;
#(
  parameter int unsigned SIG_W = 53
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SIG_W-1:0] inSum,
  input  logic [SIG_W-1:0] inCarry,
  input  logic [1:0]       inLowCarry,
  input  logic             inComplete,
  input  logic             inGuard,
  input  logic             inRound,
  input  logic             inSticky,
  output logic             outValid,
  output logic [SIG_W-1:0] outSig,
  output logic             outCarry
);

  darStrobe_t strobe;
  logic       lsbPre;

  darCtl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inGuard (inGuard),
    .inRound (inRound),
    .inSticky(inSticky),
    .lsbPre  (lsbPre),
    .strobe  (strobe),
    .outValid(outValid)
  );

  darPath #(.SIG_W(SIG_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .sumIn   (inSum),
    .carryIn (inCarry),
    .lowCarry(inLowCarry),
    .complete(inComplete),
    .lsbPre  (lsbPre),
    .rndSig  (outSig),
    .rndCarry(outCarry)
  );

  // R6: a tie always lands on an even result
  a_r6_tie_even: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inGuard && !inRound && !inSticky) |=> !outSig[0]);
  // R5: without a guard bit, no rounding happens, so a zero total stays zero
  a_r5_no_guard_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inGuard && inSum == '0 && inCarry == '0 && inLowCarry == 2'd0
     && !inComplete) |=> (outSig == '0 && !outCarry));

endmodule

// File: tb/tb_darAddRound.sv
module tb_darAddRound;

  localparam int unsigned SW = 5;
  localparam int unsigned BW = 53;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  // small instance, swept exhaustively
  logic          vS;
  logic [SW-1:0] sS, cS;
  logic [1:0]    lcS;
  logic          cpS, gS, rS, stS;
  logic          ovS;
  logic [SW-1:0] sigS;
  logic          coS;

  // full-width instance, directed corners
  logic          vB;
  logic [BW-1:0] sB, cB;
  logic [1:0]    lcB;
  logic          cpB, gB, rB, stB;
  logic          ovB;
  logic [BW-1:0] sigB;
  logic          coB;

  darAddRound #(.SIG_W(SW)) dut (
    .clk(clk), .rstN(rstN), .inValid(vS), .inSum(sS), .inCarry(cS),
    .inLowCarry(lcS), .inComplete(cpS), .inGuard(gS), .inRound(rS),
    .inSticky(stS), .outValid(ovS), .outSig(sigS), .outCarry(coS));

  darAddRound dut53 (
    .clk(clk), .rstN(rstN), .inValid(vB), .inSum(sB), .inCarry(cB),
    .inLowCarry(lcB), .inComplete(cpB), .inGuard(gB), .inRound(rB),
    .inSticky(stB), .outValid(ovB), .outSig(sigB), .outCarry(coB));

  int nChecks = 0;
  int nFails  = 0;

  task automatic chk(input string tag, input longint unsigned act,
                     input longint unsigned exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned model(input int w, input longint unsigned s,
      input longint unsigned c, input int lc, input int cp, input int g,
      input int r, input int st);
    longint unsigned tot, up;
    tot = s + c + longint'(lc) + longint'(cp);
    up  = (g != 0 && (r != 0 || st != 0 || tot[0])) ? 64'd1 : 64'd0;
    return (tot + up) & ((64'd1 << (w + 1)) - 64'd1);
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin : stim
    longint unsigned expV;
    string tag;
    logic [SW-1:0] holdSig;
    logic holdCo;
    vS = 0; sS = '0; cS = '0; lcS = 0; cpS = 0; gS = 0; rS = 0; stS = 0;
    vB = 0; sB = '0; cB = '0; lcB = 0; cpB = 0; gB = 0; rB = 0; stB = 0;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 valid", ovS, 0);
    chk("R10 sig", sigS, 0);
    chk("R10 carry", coS, 0);
    chk("R10 valid53", ovB, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R8 idle after reset", ovS, 0);

    // exhaustive sweep of the small configuration, one vector per cycle
    for (int s = 0; s < 32; s++)
      for (int c = 0; c < 32; c++)
        for (int lc = 0; lc < 3; lc++)
          for (int cp = 0; cp < 2; cp++)
            for (int grs = 0; grs < 8; grs++) begin
              @(negedge clk);
              vS = 1; sS = SW'(s); cS = SW'(c); lcS = 2'(lc); cpS = cp[0];
              gS = grs[2]; rS = grs[1]; stS = grs[0];
              expV = model(SW, s, c, lc, cp, grs[2], grs[1], grs[0]);
              if (grs == 4)              tag = "R6";
              else if (grs[2] == 0)      tag = "R5";
              else if (expV[SW])         tag = "R7";
              else if (lc == 2)          tag = "R2";
              else if (cp == 1)          tag = "R3";
              else if (grs[2] == 1)      tag = "R4";
              else                       tag = "R1";
              @(posedge clk); #1;
              chk("R8 valid", ovS, 1);
              chk({tag, " sig"}, sigS, expV[SW-1:0]);
              chk({tag, " carry"}, coS, expV[SW]);
              if (grs == 4) chk("R6 even", sigS[0], 0);
            end

    // R9: idle cycle with changed inputs leaves the result unchanged
    holdSig = sigS; holdCo = coS;
    @(negedge clk);
    vS = 0; sS = 5'd7; cS = 5'd9; gS = 1; rS = 1; stS = 1; cpS = 1;
    @(posedge clk); #1;
    chk("R8 valid drop", ovS, 0);
    chk("R9 sig held", sigS, holdSig);
    chk("R9 carry held", coS, holdCo);
    @(posedge clk); #1;
    chk("R9 sig held 2", sigS, holdSig);

    // R1: a fresh vector after idle
    @(negedge clk);
    vS = 1; sS = 5'd3; cS = 5'd4; lcS = 2'd1; cpS = 0; gS = 0; rS = 1; stS = 0;
    @(posedge clk); #1;
    chk("R1 after idle", sigS, 5'd8);
    chk("R8 valid rise", ovS, 1);
    @(negedge clk); vS = 0;

    // full-width corners
    for (int k = 0; k < 5; k++) begin
      longint unsigned s, c;
      int lc, cp, g, r, st;
      case (k)
        0: begin s = (64'd1 << 53) - 1; c = 0; lc = 0; cp = 0; g = 1; r = 1; st = 0; tag = "R7 full overflow"; end
        1: begin s = 64'd1 << 52; c = (64'd1 << 52) - 1; lc = 2; cp = 1; g = 1; r = 0; st = 0; tag = "R6 full tie"; end
        2: begin s = 12345; c = 678; lc = 1; cp = 0; g = 0; r = 1; st = 1; tag = "R5 full no guard"; end
        3: begin s = 5; c = 2; lc = 0; cp = 0; g = 1; r = 0; st = 0; tag = "R6 full tie odd"; end
        default: begin s = 64'h0F0F_0F0F_0F0F_0; c = 64'h10_F0F0_F0F0_F0F0; lc = 2; cp = 1; g = 1; r = 0; st = 1; tag = "R4 full sticky"; end
      endcase
      @(negedge clk);
      vB = 1; sB = BW'(s); cB = BW'(c); lcB = 2'(lc); cpB = cp[0];
      gB = g[0]; rB = r[0]; stB = st[0];
      expV = model(BW, s & ((64'd1 << BW) - 1), c & ((64'd1 << BW) - 1), lc, cp, g, r, st);
      @(posedge clk); #1;
      chk({tag, " sig"}, sigB, expV[BW-1:0]);
      chk({tag, " carry"}, coB, expV[BW]);
      chk("R8 valid53", ovB, 1);
    end
    @(negedge clk); vB = 0;
    @(posedge clk); #1;
    chk("R8 idle53", ovB, 0);

    finish_run();
  end

endmodule